// File: doc/BRIEF.md
# Framebuffer Line Scanout with Vertical Repeat

This block turns a byte-per-pixel framebuffer into a live colour stream for a raster display. A separate sync generator tells it when a frame begins, when each display line begins and which cycles carry visible pixels. The block fetches each stored row from framebuffer memory into a small two-bank line buffer and plays it out on the pixel-enable cycles. The colour outputs are held at zero at every other time.

Rows are laid out in memory with a padded stride. Each row's byte count rounds the visible width plus one up to a multiple of 16. The extra slot stands for the black pixel that closes every line. The padding is never read. A repeat factor makes every stored row appear on several consecutive display lines. The row is read from memory once, when its prefetch starts, and every display of it comes from the line buffer.

The fetch of a row into the idle bank starts at the line start that opens the previous row's first display. After a frame start, row 0 is fetched straight away. The sync generator must follow three timing rules. It must leave at least H_PIX+3 cycles between a frame start and the first line start. It must leave at least H_PIX+3 cycles between line starts that open a new row. It must hold pixel-enable low for the two cycles after a line start.

Top module: `fbs_scanout`

## Requirements
- R1: The framebuffer byte maps to the outputs as red = bits 7:5, green = bits 4:2 and blue = bits 1:0.
- R2: In the cycle after the k-th pixel-enable cycle of a line, for k from 0 to H_PIX-1, the outputs carry byte k of the row shown on that line. Pixel-enable low cycles inside the line do not advance k.
- R3: In the cycle after any cycle with pixel-enable low, all colour outputs are zero.
- R4: Pixel-enable cycles beyond the H_PIX-th in a line produce black (all outputs zero).
- R5: Row r starts at byte address r*STRIDE, where STRIDE = (H_PIX + 1 + 15) rounded down to a multiple of 16 (80 for H_PIX = 64). The block never reads addresses whose offset within the row is H_PIX or more.
- R6: Display line l (counted from 0 after a frame start) shows row floor(l / REPEAT).
- R7: Each row is read from memory exactly once per frame, so a frame makes ROWS*H_PIX reads, where ROWS = V_LINES / REPEAT. Duplicate lines replay the buffered copy, so memory writes made after the fetch do not show.
- R8: A frame start resets the row and column addresses. The first read, at address 0, appears on fb_rd two cycles after frame_start is sampled.
- R9: Read data is taken from fb_rdata one cycle after the read request, matching a synchronous memory.
- R10: During and directly after reset the colour outputs are zero and no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse before the first line of a frame |
| line_start | input | 1 | One-cycle pulse opening each display line |
| de | input | 1 | Pixel-enable from the sync generator |
| fb_rd | output | 1 | Framebuffer read request |
| fb_addr | output | AW | Framebuffer byte address |
| fb_rdata | input | 8 | Read data, valid one cycle after fb_rd |
| red | output | 3 | Red level |
| green | output | 3 | Green level |
| blue | output | 2 | Blue level |

## Verification
Some rules are checked on every cycle by assertions. These are the zero colour after a cycle without pixel-enable, reads that stay inside a row's visible bytes and inside the framebuffer, the per-frame read budget, the first read at address 0 after a frame start, and the quiet state after reset. Other behaviour needs stimulus with a known memory image, so only the bench scenarios can show it. This covers pixel order across gaps in pixel-enable, the forced black for surplus enable cycles, the mapping of lines to rows under repeat, and duplicate lines replaying stale buffered data after memory is rewritten.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef struct packed {
    logic [2:0] r;
    logic [2:0] g;
    logic [1:0] b;
  } rgb332_t;

  // Bytes per stored row: visible pixels plus the closing black slot,
  // rounded up to a 16-byte boundary.
  function automatic int row_stride(int h_pix);
    return ((h_pix + 1 + 15) / 16) * 16;
  endfunction

endpackage

// File: rtl/fbs_fetch.sv
module fbs_fetch #(
  parameter int H_PIX = 64,
  parameter int AW    = 16,
  localparam int IW   = $clog2(H_PIX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] go_base,
  input  logic          go_bank,
  output logic          fb_rd,
  output logic [AW-1:0] fb_addr,
  input  logic [7:0]    fb_rdata,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data
);

  localparam logic [IW-1:0] LAST = IW'(H_PIX - 1);

  logic          busy;
  logic [IW-1:0] cnt;
  logic [AW-1:0] cur;
  logic          bank;
  logic [IW-1:0] req_idx;
  logic          req_bank;

  // Issue stage: walks one row's visible bytes.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      cur  <= '0;
      bank <= 1'b0;
    end else if (go) begin
      busy <= 1'b1;
      cnt  <= '0;
      cur  <= go_base;
      bank <= go_bank;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      cur <= cur + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end
  end

  // Registered request to memory, with the tag of where the byte goes.
  always_ff @(posedge clk) begin
    if (rst) begin
      fb_rd    <= 1'b0;
      fb_addr  <= '0;
      req_idx  <= '0;
      req_bank <= 1'b0;
    end else begin
      fb_rd    <= busy;
      fb_addr  <= cur;
      req_idx  <= cnt;
      req_bank <= bank;
    end
  end

  // Capture stage: memory answers one cycle after the request.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_bank <= 1'b0;
      wr_idx  <= '0;
    end else begin
      wr_en   <= fb_rd;
      wr_bank <= req_bank;
      wr_idx  <= req_idx;
    end
  end

  assign wr_data = fb_rdata;

endmodule

// File: rtl/fbs_linebuf.sv
module fbs_linebuf #(
  parameter int H_PIX = 64,
  localparam int IW    = $clog2(H_PIX),
  localparam int DEPTH = 2 * H_PIX,
  localparam int LW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic          rd_bank,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data
);

  logic [7:0]    store [DEPTH];
  logic [LW-1:0] wa;
  logic [LW-1:0] ra;

  assign wa = wr_bank ? LW'(H_PIX) + LW'(wr_idx) : LW'(wr_idx);
  assign ra = rd_bank ? LW'(H_PIX) + LW'(rd_idx) : LW'(rd_idx);

  always_ff @(posedge clk) begin
    if (wr_en) store[wa] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= store[ra];
  end

endmodule

// File: rtl/fbs_pixout.sv
module fbs_pixout
  import fbs_pkg::*;
#(
  parameter int H_PIX = 64,
  localparam int IW   = $clog2(H_PIX),
  localparam int CW   = $clog2(H_PIX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic          de,
  output logic [IW-1:0] rd_idx,
  input  logic [7:0]    rd_data,
  output rgb332_t       pix
);

  localparam logic [CW-1:0] HEND = CW'(H_PIX);

  logic [CW-1:0] col;
  logic [CW-1:0] col_d;

  // The buffer address runs on the next column value, so its one-cycle
  // read already holds the pixel when pixel-enable arrives.
  always_comb begin
    if (line_start)                col_d = '0;
    else if (de && (col < HEND))   col_d = col + 1'b1;
    else                           col_d = col;
  end

  assign rd_idx = (col_d < HEND) ? col_d[IW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) col <= '0;
    else     col <= col_d;
  end

  // Registered colour: zero outside pixel-enable and on surplus slots.
  always_ff @(posedge clk) begin
    if (rst)                      pix <= '0;
    else if (de && (col < HEND))  pix <= rgb332_t'(rd_data);
    else                          pix <= '0;
  end

endmodule

// File: rtl/fbs_scanout.sv
module fbs_scanout
  import fbs_pkg::*;
#(
  parameter int H_PIX   = 64,
  parameter int V_LINES = 48,
  parameter int REPEAT  = 2,
  parameter int AW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          line_start,
  input  logic          de,
  output logic          fb_rd,
  output logic [AW-1:0] fb_addr,
  input  logic [7:0]    fb_rdata,
  output logic [2:0]    red,
  output logic [2:0]    green,
  output logic [1:0]    blue
);

  localparam int STRIDE = row_stride(H_PIX);
  localparam int ROWS   = V_LINES / REPEAT;
  localparam int IW     = $clog2(H_PIX);
  localparam int RPW    = $clog2(REPEAT + 1);
  localparam int RCW    = $clog2(ROWS + 1);
  localparam logic [RPW-1:0] REP_LAST = RPW'(REPEAT - 1);
  localparam logic [RCW-1:0] ROWS_C   = RCW'(ROWS);

  logic           disp_bank;
  logic [RPW-1:0] rep;
  logic [AW-1:0]  nxt_addr;
  logic [RCW-1:0] fetched;

  logic           new_row;
  logic           go;
  logic [AW-1:0]  go_base;
  logic           go_bank;

  logic           wr_en;
  logic           wr_bank;
  logic [IW-1:0]  wr_idx;
  logic [7:0]     wr_data;
  logic [IW-1:0]  rd_idx;
  logic [7:0]     rd_data;
  rgb332_t        pix;

  // A line opening a new row swaps banks; the freed bank takes the
  // following row while this one is shown REPEAT times.
  assign new_row = line_start && (rep == '0);
  assign go      = frame_start || (new_row && (fetched < ROWS_C));
  assign go_base = frame_start ? '0 : nxt_addr;
  assign go_bank = frame_start ? 1'b1 : disp_bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_bank <= 1'b0;
      rep       <= '0;
      nxt_addr  <= '0;
      fetched   <= '0;
    end else if (frame_start) begin
      disp_bank <= 1'b0;
      rep       <= '0;
      nxt_addr  <= AW'(STRIDE);
      fetched   <= RCW'(1);
    end else if (line_start) begin
      rep <= (rep == REP_LAST) ? '0 : rep + 1'b1;
      if (new_row) begin
        disp_bank <= ~disp_bank;
        if (fetched < ROWS_C) begin
          nxt_addr <= nxt_addr + AW'(STRIDE);
          fetched  <= fetched + 1'b1;
        end
      end
    end
  end

  fbs_fetch #(.H_PIX(H_PIX), .AW(AW)) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .go_base  (go_base),
    .go_bank  (go_bank),
    .fb_rd    (fb_rd),
    .fb_addr  (fb_addr),
    .fb_rdata (fb_rdata),
    .wr_en    (wr_en),
    .wr_bank  (wr_bank),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  fbs_linebuf #(.H_PIX(H_PIX)) u_buf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_bank (wr_bank),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_bank (disp_bank),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  fbs_pixout #(.H_PIX(H_PIX)) u_pix (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .de         (de),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .pix        (pix)
  );

  assign red   = pix.r;
  assign green = pix.g;
  assign blue  = pix.b;

endmodule

// File: rtl/fbs_scanout_chk.sv
module fbs_scanout_chk #(
  parameter int H_PIX   = 64,
  parameter int V_LINES = 48,
  parameter int REPEAT  = 2,
  parameter int AW      = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_start,
  input logic          de,
  input logic          fb_rd,
  input logic [AW-1:0] fb_addr,
  input logic [2:0]    red,
  input logic [2:0]    green,
  input logic [1:0]    blue
);

  localparam int STRIDE = fbs_pkg::row_stride(H_PIX);
  localparam int ROWS   = V_LINES / REPEAT;

  logic rst_q = 1'b0;
  int   rd_cnt;

  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst || frame_start) rd_cnt <= 0;
    else if (fb_rd)         rd_cnt <= rd_cnt + 1;
  end

  p_blank_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !de |=> ({red, green, blue} == 8'h00));

  p_no_pad_read_r5: assert property (@(posedge clk) disable iff (rst)
    fb_rd |-> ((int'(fb_addr) % STRIDE) < H_PIX) && (int'(fb_addr) < ROWS * STRIDE));

  p_read_budget_r7: assert property (@(posedge clk) disable iff (rst)
    rd_cnt <= ROWS * H_PIX);

  p_first_read_r8: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> ##2 (fb_rd && (fb_addr == '0)));

  p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (!fb_rd && ({red, green, blue} == 8'h00)));

endmodule

bind fbs_scanout fbs_scanout_chk #(
  .H_PIX(H_PIX), .V_LINES(V_LINES), .REPEAT(REPEAT), .AW(AW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .de          (de),
  .fb_rd       (fb_rd),
  .fb_addr     (fb_addr),
  .red         (red),
  .green       (green),
  .blue        (blue)
);

// File: tb/fbs_scanout_test.sv
module fbs_scanout_test;

  localparam int H_PIX    = 64;
  localparam int V_LINES  = 48;
  localparam int REPEAT   = 2;
  localparam int AW       = 16;
  localparam int STRIDE   = ((H_PIX + 1 + 15) / 16) * 16;
  localparam int ROWS     = V_LINES / REPEAT;
  localparam int FB_BYTES = ROWS * STRIDE;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_start = 1'b0;
  logic          line_start = 1'b0;
  logic          de = 1'b0;
  logic          fb_rd;
  logic [AW-1:0] fb_addr;
  logic [7:0]    fb_rdata = 8'h00;
  logic [2:0]    red;
  logic [2:0]    green;
  logic [1:0]    blue;

  logic [7:0] mem    [FB_BYTES];
  logic [7:0] shadow [FB_BYTES];

  int checks = 0;
  int fails  = 0;
  int reads  = 0;

  always #10 clk = ~clk;

  fbs_scanout #(.H_PIX(H_PIX), .V_LINES(V_LINES), .REPEAT(REPEAT), .AW(AW)) uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
    .de(de), .fb_rd(fb_rd), .fb_addr(fb_addr), .fb_rdata(fb_rdata),
    .red(red), .green(green), .blue(blue)
  );

  // Synchronous memory model with one cycle of read latency (R9).
  always @(posedge clk) begin
    if (fb_rd) fb_rdata <= (int'(fb_addr) < FB_BYTES) ? mem[int'(fb_addr)] : 8'h00;
  end

  // Read monitor, sampled at the falling edge (R5).
  always @(negedge clk) begin
    if (fb_rd && !rst) begin
      reads++;
      checks++;
      if ((int'(fb_addr) % STRIDE) >= H_PIX || int'(fb_addr) >= FB_BYTES) begin
        fails++;
        $display("FAIL R5 read address actual %0d expected visible byte below %0d", fb_addr, FB_BYTES);
      end
    end
  end

  task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs, then check the registered colour.
  task automatic cyc(input logic fs, input logic ls, input logic d,
                     input logic [7:0] e, input string tag);
    frame_start = fs;
    line_start  = ls;
    de          = d;
    @(negedge clk);
    #1;
    chk8({red, green, blue}, e, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) cyc(1'b0, 1'b0, 1'b0, 8'h00, "R3 blank");
  endtask

  // mode 0: random gaps and surplus enables; mode 1: rewrite row 0
  // between its two displays; mode 2: clean back-to-back lines.
  task automatic run_frame(input int mode);
    for (int i = 0; i < FB_BYTES; i++) shadow[i] = mem[i];
    reads = 0;
    cyc(1'b1, 1'b0, 1'b0, 8'h00, "R3 blank");
    cyc(1'b0, 1'b0, 1'b0, 8'h00, "R3 blank");
    chk8({7'd0, fb_rd}, 8'h01, "R8 first read issued");
    chk_int(int'(fb_addr), 0, "R8 first read address");
    idle(H_PIX + 8);
    for (int l = 0; l < V_LINES; l++) begin
      int row = l / REPEAT;
      int col = 0;
      string tag;
      tag = (mode == 1 && l == 1) ? "R7 duplicate replays buffered row" : "R1 R2 R6 pixel";
      if (mode == 1 && l == 1) begin
        for (int c = 0; c < STRIDE; c++) mem[c] = ~shadow[c];
      end
      cyc(1'b0, 1'b1, 1'b0, 8'h00, "R3 blank");
      idle(2 + int'($urandom % 3));
      while (col < H_PIX) begin
        if (mode != 2 && ($urandom % 8) == 0) begin
          cyc(1'b0, 1'b0, 1'b0, 8'h00, "R3 enable gap");
        end else begin
          cyc(1'b0, 1'b0, 1'b1, shadow[row * STRIDE + col], tag);
          col++;
        end
      end
      if (mode != 2) begin
        repeat (int'($urandom % 3)) cyc(1'b0, 1'b0, 1'b1, 8'h00, "R4 surplus enable");
      end else begin
        cyc(1'b0, 1'b0, 1'b1, 8'h00, "R4 surplus enable");
      end
      idle(8);
    end
    idle(4);
    chk_int(reads, ROWS * H_PIX, "R7 reads per frame");
  endtask

  initial begin
    void'($urandom(32'h5EED_0F1B));
    for (int i = 0; i < FB_BYTES; i++) mem[i] = 8'($urandom);
    repeat (4) @(negedge clk);
    #1;
    chk8({red, green, blue}, 8'h00, "R10 colour in reset");
    chk8({7'd0, fb_rd}, 8'h00, "R10 no read in reset");
    rst = 1'b0;
    idle(3);
    chk8({7'd0, fb_rd}, 8'h00, "R10 no read before frame");
    run_frame(0);
    run_frame(1);
    for (int i = 0; i < FB_BYTES; i++) mem[i] = 8'($urandom);
    run_frame(2);
    run_frame(0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog for all requirements actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule